// File: doc/BRIEF.md
# Pulse-width coded motor command transmitter

This block turns one motor command into a serial pulse train on a single line. A command is an 11-bit throttle value plus a telemetry-request flag. The block packs these into a 16-bit word, adds a 4-bit check nibble, and sends the word most significant bit first. Every bit occupies one fixed slot of `bit_period` clocks. Within a slot, the line is active for a long interval to send a one and for a short interval to send a zero. Four empty slots follow the 16 data slots, so each frame is 20 slots long.

A mode input selects the bidirectional variant. In that mode the check nibble is inverted and the line polarity is flipped, so the line rests high and pulses go low.

Commands arrive on a valid/ready handshake. `cmd_ready` is high only while no frame is in flight, and the handshake has no other back-pressure. The source holds `cmd_valid` and its data until it sees `cmd_ready` high at a clock edge. The block latches the data, the mode and the period at that edge. From then until the frame ends, changes on those inputs have no effect.

Top module: `dshot_tx`

## Requirements
- R1: After reset, `cmd_ready` is 1, `frame_done` is 0, and `line_out` equals the `bidir` input (low when `bidir` is 0).
- R2: Frame bits 15..5 hold the throttle, bit 4 holds the telemetry flag, and bits 3..0 hold the check nibble. The check nibble is the XOR of frame bits 15..12, 11..8 and 7..4. Slot i (i = 0..15) carries frame bit 15-i.
- R3: Every slot lasts exactly P clocks, where P is the effective period. The line is active at the start of the slot for floor(P*767/1024) clocks for a one and floor(P*379/1024) clocks for a zero, then inactive for the rest of the slot.
- R4: A frame has 20 slots. Slots 16..19 carry no active time.
- R5: With `bidir` = 1 latched at load, the check nibble is bitwise inverted and the line is active low. While idle, `line_out` follows the `bidir` input, so it rests high in that mode.
- R6: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. Slot 0 begins in the next cycle, and `cmd_ready` stays 0 for the whole frame. A `cmd_valid` raised while busy is ignored.
- R7: `frame_done` is high for exactly one cycle: the cycle right after the last clock of slot 19. `cmd_ready` is 1 in that same cycle. A command accepted there starts the next frame with no idle slot in between.
- R8: The effective period is `bit_period` saturated to MAX_PERIOD = CLK_HZ/MIN_RATE (1666 by default). A value of 0 is treated as 1.
- R9: The active-time lengths, period, mode and frame word are all latched at acceptance. Changing `bit_period`, `bidir`, `throttle` or `telem_req` during a frame does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| throttle | input | 11 | Throttle value |
| telem_req | input | 1 | Telemetry request flag |
| bidir | input | 1 | Bidirectional mode select |
| bit_period | input | PW (16) | Slot length in clocks |
| line_out | output | 1 | Serial pulse line |
| frame_done | output | 1 | One-cycle end-of-frame strobe |

## Verification
The end-of-frame strobe and the acceptance of the next command can fall in the same cycle, because `cmd_ready` returns high exactly when `frame_done` fires. The bench provokes this by presenting a second command at the sampling point of the `frame_done` cycle. It then requires both of the following:
- the strobe and ready were both high in that cycle;
- the second frame's slot 0 starts on the very next cycle, with correct active times throughout.

A second case offers a command in the middle of a frame. Here the bench requires that the command is dropped and that the running frame is left untouched.

// File: rtl/dshot_pkg.sv
package dshot_pkg;
  localparam int FRAME_BITS = 16;
  localparam int TAIL_SLOTS = 4;
  localparam int SLOTS      = FRAME_BITS + TAIL_SLOTS;
  localparam int THR_W      = 11;
  localparam int FRAC_SHIFT = 10;
  localparam int ONE_NUM    = 767;
  localparam int ZERO_NUM   = 379;

  function automatic logic [FRAME_BITS-1:0] make_frame(
    input logic [THR_W-1:0] thr,
    input logic             tlm,
    input logic             inv
  );
    logic [FRAME_BITS-5:0] head;
    logic [3:0]            cs;
    head = {thr, tlm};
    cs   = head[11:8] ^ head[7:4] ^ head[3:0] ^ {4{inv}};
    return {head, cs};
  endfunction
endpackage

// File: rtl/dshot_duty_calc.sv
module dshot_duty_calc #(
  parameter int PW         = 16,
  parameter int MAX_PERIOD = 1666
) (
  input  logic [PW-1:0] period_raw,
  output logic [PW-1:0] period_eff,
  output logic [PW-1:0] hi_one,
  output logic [PW-1:0] hi_zero
);
  import dshot_pkg::*;
  localparam int PROD_W = PW + FRAC_SHIFT;

  logic [PROD_W-1:0] prod_one, prod_zero;

  always_comb begin
    if (period_raw == '0)
      period_eff = PW'(1);
    else if (period_raw > PW'(MAX_PERIOD))
      period_eff = PW'(MAX_PERIOD);
    else
      period_eff = period_raw;
    prod_one  = PROD_W'(period_eff) * PROD_W'(ONE_NUM);
    prod_zero = PROD_W'(period_eff) * PROD_W'(ZERO_NUM);
    hi_one    = prod_one[PROD_W-1:FRAC_SHIFT];
    hi_zero   = prod_zero[PROD_W-1:FRAC_SHIFT];
  end
endmodule

// File: rtl/dshot_slot_seq.sv
module dshot_slot_seq #(
  parameter int PW = 16,
  parameter int SW = $clog2(dshot_pkg::SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] period,
  output logic          busy,
  output logic [SW-1:0] slot,
  output logic [PW-1:0] tick,
  output logic          done
);
  import dshot_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      slot <= '0;
      tick <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          slot <= '0;
          tick <= '0;
        end
      end else if (tick == period - PW'(1)) begin
        tick <= '0;
        if (slot == SW'(SLOTS-1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          slot <= slot + SW'(1);
        end
      end else begin
        tick <= tick + PW'(1);
      end
    end
  end
endmodule

// File: rtl/dshot_tx.sv
module dshot_tx #(
  parameter int CLK_HZ   = 250_000_000,
  parameter int MIN_RATE = 150_000,
  parameter int PW       = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic [dshot_pkg::THR_W-1:0] throttle,
  input  logic                        telem_req,
  input  logic                        bidir,
  input  logic [PW-1:0]               bit_period,
  output logic                        line_out,
  output logic                        frame_done
);
  import dshot_pkg::*;
  localparam int MAX_PERIOD = CLK_HZ / MIN_RATE;
  localparam int SW         = $clog2(SLOTS);
  localparam int BIW        = $clog2(FRAME_BITS);

  logic                  busy;
  logic [SW-1:0]         slot_idx;
  logic [PW-1:0]         tick;
  logic [PW-1:0]         per_eff, hi1_c, hi0_c;
  logic [PW-1:0]         per_q, hi1_q, hi0_q, hi_len;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  inv_q, accept, data_slot, pulse;
  logic [BIW-1:0]        bidx;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;

  dshot_duty_calc #(.PW(PW), .MAX_PERIOD(MAX_PERIOD)) u_duty (
    .period_raw (bit_period),
    .period_eff (per_eff),
    .hi_one     (hi1_c),
    .hi_zero    (hi0_c)
  );

  dshot_slot_seq #(.PW(PW), .SW(SW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .period (per_q),
    .busy   (busy),
    .slot   (slot_idx),
    .tick   (tick),
    .done   (frame_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      per_q   <= PW'(1);
      hi1_q   <= '0;
      hi0_q   <= '0;
      inv_q   <= 1'b0;
    end else if (accept) begin
      frame_q <= make_frame(throttle, telem_req, bidir);
      per_q   <= per_eff;
      hi1_q   <= hi1_c;
      hi0_q   <= hi0_c;
      inv_q   <= bidir;
    end
  end

  always_comb begin
    data_slot = slot_idx < SW'(FRAME_BITS);
    bidx      = BIW'(FRAME_BITS-1) - slot_idx[BIW-1:0];
    if (!data_slot)
      hi_len = '0;
    else if (frame_q[bidx])
      hi_len = hi1_q;
    else
      hi_len = hi0_q;
    pulse    = busy && (tick < hi_len);
    line_out = busy ? (pulse ^ inv_q) : bidir;
  end
endmodule

// File: rtl/dshot_tx_chk.sv
module dshot_tx_chk (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               cmd_valid,
  input logic                               cmd_ready,
  input logic                               frame_done,
  input logic                               busy,
  input logic [$clog2(dshot_pkg::SLOTS)-1:0] slot_idx
);
  localparam int SW = $clog2(dshot_pkg::SLOTS);

  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> cmd_ready); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(!cmd_ready)); // R7
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R6
  AST_READY_RISE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_ready) |-> frame_done); // R6
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (slot_idx < SW'(dshot_pkg::SLOTS))); // R4
endmodule

bind dshot_tx dshot_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .frame_done (frame_done),
  .busy       (busy),
  .slot_idx   (slot_idx)
);

// File: tb/sim_dshot_tx.sv
module sim_dshot_tx;
  localparam int PW      = 16;
  localparam int MAXP    = 250_000_000 / 150_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [10:0] throttle = '0;
  logic telem_req = 1'b0;
  logic bidir = 1'b0;
  logic [PW-1:0] bit_period = 16'd10;
  logic line_out, frame_done;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  dshot_tx u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .throttle(throttle), .telem_req(telem_req), .bidir(bidir),
    .bit_period(bit_period), .line_out(line_out), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_p(input int p);
    if (p == 0) return 1;
    if (p > MAXP) return MAXP;
    return p;
  endfunction

  function automatic int exp_hi(input int p, input bit b);
    int pe;
    pe = eff_p(p);
    return b ? (pe * 767) / 1024 : (pe * 379) / 1024;
  endfunction

  function automatic logic [15:0] exp_frame(input logic [10:0] th, input bit t, input bit bd);
    logic [15:0] f;
    logic [3:0] c;
    f = {th, t, 4'b0000};
    c = f[15:12] ^ f[11:8] ^ f[7:4];
    if (bd) c = ~c;
    return {f[15:4], c};
  endfunction

  // called at a negedge with the block idle; returns at negedge of slot 0 cycle 0
  task automatic load(input logic [10:0] th, input bit t, input bit bd, input int p);
    throttle = th; telem_req = t; bidir = bd; bit_period = PW'(p); cmd_valid = 1'b1;
    chk(cmd_ready == 1'b1, "R6 ready before load", int'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // measures all 20 slots; returns at negedge of the cycle after the frame
  task automatic capture(input logic [10:0] th, input bit t, input bit bd, input int p,
                         input bit inject, input string tag);
    logic [15:0] f;
    int pe, cnt, busy_bad, ebit, ehi;
    f = exp_frame(th, t, bd);
    pe = eff_p(p);
    busy_bad = 0;
    for (int s = 0; s < 20; s++) begin
      cnt = 0;
      for (int k = 0; k < pe; k++) begin
        if (line_out == !bd) cnt++;
        if (cmd_ready || frame_done) busy_bad++;
        if (inject && s == 5 && k == 0) begin
          cmd_valid = 1'b1; throttle = ~th; telem_req = !t; bidir = !bd;
          bit_period = PW'(p + 7);
        end
        if (inject && s == 6 && k == 0) begin
          cmd_valid = 1'b0; bidir = bd; bit_period = PW'(p);
        end
        @(negedge clk);
      end
      if (s < 16) begin
        ebit = int'(f[15-s]);
        ehi = exp_hi(p, ebit[0]);
        chk(cnt == ehi, $sformatf("R2/R3 %s slot %0d", tag, s), cnt, ehi);
      end else begin
        chk(cnt == 0, $sformatf("R4 %s tail slot %0d", tag, s), cnt, 0);
      end
    end
    chk(busy_bad == 0, $sformatf("R6 %s ready/done low in frame", tag), busy_bad, 0);
    chk(frame_done == 1'b1, $sformatf("R7 %s done after last slot", tag), int'(frame_done), 1);
    chk(cmd_ready == 1'b1, $sformatf("R7 %s ready with done", tag), int'(cmd_ready), 1);
  endtask

  task automatic idle_after(input bit bd, input string tag);
    @(negedge clk);
    chk(frame_done == 1'b0, $sformatf("R7 %s done one cycle", tag), int'(frame_done), 0);
    chk(line_out == bd, $sformatf("R5 %s idle level", tag), int'(line_out), int'(bd));
  endtask

  task automatic t_reset;
    chk(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
    chk(frame_done == 1'b0, "R1 done", int'(frame_done), 0);
    chk(line_out == 1'b0, "R1 line", int'(line_out), 0);
  endtask

  task automatic t_basic;
    load(11'h5A3, 1'b1, 1'b0, 40);
    capture(11'h5A3, 1'b1, 1'b0, 40, 1'b0, "basic");
    idle_after(1'b0, "basic");
    load(11'h02C, 1'b0, 1'b0, 64);
    capture(11'h02C, 1'b0, 1'b0, 64, 1'b0, "basic2");
    idle_after(1'b0, "basic2");
  endtask

  task automatic t_bidir;
    bidir = 1'b1;
    @(negedge clk);
    chk(line_out == 1'b1, "R5 idle high before load", int'(line_out), 1);
    load(11'h123, 1'b0, 1'b1, 53);
    capture(11'h123, 1'b0, 1'b1, 53, 1'b0, "bidir");
    idle_after(1'b1, "bidir");
    bidir = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_busy_ignore; // R6 R9
    load(11'h7F0, 1'b1, 1'b0, 33);
    capture(11'h7F0, 1'b1, 1'b0, 33, 1'b1, "R9 ignore");
    idle_after(1'b0, "ignore");
  endtask

  task automatic t_b2b; // R7 done and accept in the same cycle
    load(11'h3C5, 1'b0, 1'b0, 30);
    capture(11'h3C5, 1'b0, 1'b0, 30, 1'b0, "b2b first");
    load(11'h4A9, 1'b1, 1'b0, 27);
    chk(frame_done == 1'b0, "R7 done cleared on next frame", int'(frame_done), 0);
    capture(11'h4A9, 1'b1, 1'b0, 27, 1'b0, "b2b second");
    idle_after(1'b0, "b2b");
  endtask

  task automatic t_clamp; // R8
    load(11'h6D6, 1'b1, 1'b0, 2000);
    capture(11'h6D6, 1'b1, 1'b0, 2000, 1'b0, "R8 clamp");
    idle_after(1'b0, "clamp");
    load(11'h7FF, 1'b1, 1'b0, 0);
    capture(11'h7FF, 1'b1, 1'b0, 0, 1'b0, "R8 zero");
    idle_after(1'b0, "zero");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_bidir();
    t_busy_ignore();
    t_b2b();
    t_clamp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule